// File: doc/BRIEF.md
# VPW Bus Frame Receiver

This block receives frames from a single-wire variable-pulse-width bus. The bus line is synchronised, the time between successive transitions is measured in microsecond ticks derived from the system clock, and each measured pulse is classified by width and level. A long active pulse opens a frame. Data pulses are then decoded into bits and assembled into bytes, most significant bit first. A long passive gap closes the data portion, and a longer passive gap closes the frame.

Completed bytes go to a read register with one further byte of storage behind it. The CPU side pops bytes with a read strobe. Sticky status flags report end of data, end of frame, a framing error (a partial byte at end of data) and an overrun (a third byte completing while two are still unread). A level interrupt request is high whenever a byte is waiting or any flag is set.

Top module: `vpw_frame_rx`

## Requirements
- R1: After reset, rx_valid, irq and all four status bits are 0.
- R2: A pulse is short if it lasts from 34 up to 96 µs and long if it lasts from 96 up to 163 µs, counted in ticks of TICK_DIV clocks. An active short or a passive long gives bit 0. An active long or a passive short gives bit 1. The active level is bus_in = 1 when ACTIVE_HIGH = 1.
- R3: An active pulse of at least 163 µs is start of frame. Data pulses seen outside a frame produce no byte and no flag.
- R4: Bits are assembled most significant bit first, and each group of 8 bits gives one byte.
- R5: A pulse shorter than 34 µs produces no bit, no byte and no flag.
- R6: A start of frame during a frame discards any partial byte and restarts assembly.
- R7: Inside a frame, a passive level held for 163 µs sets status[0] (end of data). If bits of an incomplete byte are pending at that moment, status[2] (framing error) is also set and those bits are dropped.
- R8: Inside a frame, a passive level held for 239 µs sets status[1] (end of frame) and returns the receiver to idle.
- R9: Up to two completed bytes are held. rx_data shows the oldest one, and a one-cycle rx_rd pops it, so bytes come out in arrival order.
- R10: A byte that completes while two bytes are held is dropped and sets status[3] (overrun). The held bytes are kept.
- R11: A one-cycle stat_clr clears all status bits. irq is 1 exactly when rx_valid is 1 or any status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 1 | Raw bus line, asynchronous |
| rx_rd | input | 1 | Read strobe that pops the oldest held byte |
| stat_clr | input | 1 | Clear strobe for all status flags |
| rx_data | output | 8 | Oldest held received byte |
| rx_valid | output | 1 | A byte is held in rx_data |
| status | output | 4 | Sticky flags: [0] end of data, [1] end of frame, [2] framing error, [3] overrun |
| irq | output | 1 | Interrupt request |

## Verification
Bytes are chosen to cover every pairing of level and width. 0xA5 places short and long pulses on both levels, while 0x00 and 0xFF each use only two of the four symbol kinds, so a swapped decode entry or a reversed bit order shows up as a wrong byte. Frames of one, two and three bytes separate plain delivery, the second held byte and the overrun case. Further patterns are data pulses with no start of frame, a run of glitches below the noise width, a frame cut after four bits, and a frame restarted after three bits. Each of these shows whether the framing logic ignores, flags or restarts as required.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

   // symbol events produced by the pulse meter, at most one event per cycle
   typedef struct packed {
      logic bit_ev;   // a data pulse has ended
      logic bit_val;  // decoded value of that pulse
      logic sof;      // long active pulse ended
      logic eod;      // passive level reached the end-of-data width
      logic eof;      // passive level reached the end-of-frame width
   } vpw_sym_t;

   // status flag positions
   localparam int unsigned ST_EOD = 0;
   localparam int unsigned ST_EOF = 1;
   localparam int unsigned ST_FRM = 2;
   localparam int unsigned ST_OVR = 3;
   localparam int unsigned ST_W   = 4;

endpackage

// File: rtl/vpw_bus_sync.sv
module vpw_bus_sync #(
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_in,
   output logic bus_lvl
);

   logic raw;
   logic s1_q, s2_q;

   generate
      if (ACTIVE_HIGH) begin : g_pos
         assign raw = bus_in;
      end else begin : g_neg
         assign raw = ~bus_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
      end else begin
         s1_q <= raw;
         s2_q <= s1_q;
      end
   end

   assign bus_lvl = s2_q;

endmodule

// File: rtl/vpw_pulse_meter.sv
module vpw_pulse_meter
   import vpw_rx_pkg::*;
#(
   parameter int TICK_DIV = 16,
   parameter int NOISE_US = 34,
   parameter int LONG_US  = 96,
   parameter int BREAK_US = 163,
   parameter int EOF_US   = 239
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     bus_lvl,
   output vpw_sym_t sym
);

   localparam int CW = $clog2(EOF_US + 1);
   localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] NOISE_T = CW'(NOISE_US);
   localparam logic [CW-1:0] LONG_T  = CW'(LONG_US);
   localparam logic [CW-1:0] BREAK_T = CW'(BREAK_US);
   localparam logic [CW-1:0] EOF_T   = CW'(EOF_US);
   localparam logic [DW-1:0] DIV_END = DW'(TICK_DIV - 1);

   logic [DW-1:0] div_q;
   logic          tick;
   logic          lvl_q;
   logic [CW-1:0] wcnt_q;
   logic          edge_seen;
   logic          is_short, is_long, is_break;

   assign tick      = (div_q == DIV_END);
   assign edge_seen = (bus_lvl != lvl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   // width counter starts saturated so an idle bus raises no timeout
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         wcnt_q <= EOF_T;
      end else begin
         lvl_q <= bus_lvl;
         if (edge_seen) begin
            wcnt_q <= '0;
         end else if (tick && (wcnt_q != EOF_T)) begin
            wcnt_q <= wcnt_q + 1'b1;
         end
      end
   end

   assign is_short = (wcnt_q >= NOISE_T) && (wcnt_q < LONG_T);
   assign is_long  = (wcnt_q >= LONG_T)  && (wcnt_q < BREAK_T);
   assign is_break = (wcnt_q >= BREAK_T);

   always_comb begin
      sym.bit_ev  = edge_seen && (is_short || is_long);
      sym.bit_val = lvl_q ? is_long : is_short;
      sym.sof     = edge_seen && lvl_q && is_break;
      sym.eod     = !edge_seen && !lvl_q && tick && (wcnt_q == BREAK_T - 1'b1);
      sym.eof     = !edge_seen && !lvl_q && tick && (wcnt_q == EOF_T - 1'b1);
   end

endmodule

// File: rtl/vpw_rx_assembler.sv
module vpw_rx_assembler
   import vpw_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  vpw_sym_t          sym,
   input  logic              rx_rd,
   input  logic              stat_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic [ST_W-1:0]   status
);

   localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

   logic              in_frame_q;
   logic [BCW-1:0]    bit_cnt_q;
   logic [DATA_W-1:0] shreg_q;
   logic [DATA_W-1:0] hold_q, pend_q;
   logic              hold_v, pend_v;
   logic [ST_W-1:0]   flags_q;

   logic              take_bit, byte_done;
   logic [DATA_W-1:0] new_byte;
   logic [DATA_W-1:0] hq_n, pq_n;
   logic              hv_n, pv_n, ovr_ev;
   logic [ST_W-1:0]   flags_n;

   assign take_bit  = in_frame_q && sym.bit_ev;
   assign byte_done = take_bit && (bit_cnt_q == LAST_BIT);
   assign new_byte  = {shreg_q[DATA_W-2:0], sym.bit_val};

   // framing and bit assembly
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         bit_cnt_q  <= '0;
         shreg_q    <= '0;
      end else begin
         if (sym.sof) begin
            in_frame_q <= 1'b1;
            bit_cnt_q  <= '0;
         end else if (take_bit) begin
            shreg_q   <= new_byte;
            bit_cnt_q <= byte_done ? '0 : bit_cnt_q + 1'b1;
         end else if (in_frame_q && sym.eof) begin
            in_frame_q <= 1'b0;
            bit_cnt_q  <= '0;
         end else if (in_frame_q && sym.eod) begin
            bit_cnt_q <= '0;
         end
      end
   end

   // two-entry holding store, pop first then push
   always_comb begin
      hq_n   = hold_q;
      hv_n   = hold_v;
      pq_n   = pend_q;
      pv_n   = pend_v;
      ovr_ev = 1'b0;
      if (rx_rd && hold_v) begin
         if (pend_v) begin
            hq_n = pend_q;
            pv_n = 1'b0;
         end else begin
            hv_n = 1'b0;
         end
      end
      if (byte_done) begin
         if (!hv_n) begin
            hq_n = new_byte;
            hv_n = 1'b1;
         end else if (!pv_n) begin
            pq_n = new_byte;
            pv_n = 1'b1;
         end else begin
            ovr_ev = 1'b1;
         end
      end
   end

   // sticky flags, a new event wins over a clear in the same cycle
   always_comb begin
      flags_n = stat_clr ? '0 : flags_q;
      if (in_frame_q && sym.eod) begin
         flags_n[ST_EOD] = 1'b1;
         if (bit_cnt_q != '0) flags_n[ST_FRM] = 1'b1;
      end
      if (in_frame_q && sym.eof) flags_n[ST_EOF] = 1'b1;
      if (ovr_ev) flags_n[ST_OVR] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         hold_v  <= 1'b0;
         pend_q  <= '0;
         pend_v  <= 1'b0;
         flags_q <= '0;
      end else begin
         hold_q  <= hq_n;
         hold_v  <= hv_n;
         pend_q  <= pq_n;
         pend_v  <= pv_n;
         flags_q <= flags_n;
      end
   end

   assign rx_data  = hold_q;
   assign rx_valid = hold_v;
   assign status   = flags_q;

   // R9
   pend_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v |-> hold_v);

   // R10
   ovr_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[ST_OVR]) |-> ($past(hold_v) && $past(pend_v)));

   // R8
   eof_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sym.eof && !sym.sof) |=> !in_frame_q);

   // R7
   frm_with_eod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[ST_FRM]) |-> flags_q[ST_EOD]);

endmodule

// File: rtl/vpw_frame_rx.sv
module vpw_frame_rx
   import vpw_rx_pkg::*;
#(
   parameter int TICK_DIV    = 16,
   parameter int NOISE_US    = 34,
   parameter int LONG_US     = 96,
   parameter int BREAK_US    = 163,
   parameter int EOF_US      = 239,
   parameter int DATA_W      = 8,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_in,
   input  logic              rx_rd,
   input  logic              stat_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic [ST_W-1:0]   status,
   output logic              irq
);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (!(NOISE_US > 0 && NOISE_US < LONG_US && LONG_US < BREAK_US && BREAK_US < EOF_US)) begin : g_bad_thr
         $error("pulse width thresholds must be strictly increasing");
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic     bus_lvl;
   vpw_sym_t sym;

   vpw_bus_sync #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_in  (bus_in),
      .bus_lvl (bus_lvl)
   );

   vpw_pulse_meter #(
      .TICK_DIV (TICK_DIV),
      .NOISE_US (NOISE_US),
      .LONG_US  (LONG_US),
      .BREAK_US (BREAK_US),
      .EOF_US   (EOF_US)
   ) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_lvl (bus_lvl),
      .sym     (sym)
   );

   vpw_rx_assembler #(.DATA_W(DATA_W)) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym      (sym),
      .rx_rd    (rx_rd),
      .stat_clr (stat_clr),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .status   (status)
   );

   assign irq = rx_valid | (|status);

   // R2
   one_symbol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({sym.bit_ev, sym.sof, sym.eod, sym.eof}) <= 1);

endmodule

// File: tb/test_vpw_frame_rx.sv
module test_vpw_frame_rx;

   localparam int TD = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_in = 1'b0;
   logic       rx_rd = 1'b0;
   logic       stat_clr = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic [3:0] status;
   logic       irq;

   int  errs = 0;
   int  checks = 0;
   bit  cur = 1'b0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   vpw_frame_rx #(.TICK_DIV(TD)) i_vpw_frame_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_in   (bus_in),
      .rx_rd    (rx_rd),
      .stat_clr (stat_clr),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .status   (status),
      .irq      (irq)
   );

   task automatic wait_clks(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic hold(input bit lvl, input int us);
      bus_in = lvl;
      cur    = lvl;
      wait_clks(us * TD);
   endtask

   task automatic send_sof();
      hold(1'b1, 200);
   endtask

   // R2: active short/passive long = 0, active long/passive short = 1
   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         bit nl;
         nl = !cur;
         if (nl) hold(nl, b[i] ? 128 : 64);
         else    hold(nl, b[i] ? 64 : 128);
      end
   endtask

   task automatic end_frame();
      hold(1'b0, 300);
   endtask

   task automatic pulse_rd();
      rx_rd = 1'b1;
      wait_clks(1);
      rx_rd = 1'b0;
   endtask

   task automatic clear_all();
      stat_clr = 1'b1;
      wait_clks(1);
      stat_clr = 1'b0;
      for (int k = 0; k < 3; k++) if (rx_valid) pulse_rd();
   endtask

   task automatic t_reset();
      check("R1", "rx_valid", rx_valid, 0);
      check("R1", "status", status, 0);
      check("R1", "irq", irq, 0);
   endtask

   task automatic t_single();
      send_sof();
      send_bits(8'hA5, 8);
      end_frame();
      check("R2", "byte A5", rx_data, 8'hA5);
      check("R4", "rx_valid", rx_valid, 1);
      check("R7", "eod flag", status[0], 1);
      check("R8", "eof flag", status[1], 1);
      check("R7", "no framing err", status[2], 0);
      check("R11", "irq set", irq, 1);
      pulse_rd();
      check("R9", "empty after read", rx_valid, 0);
      stat_clr = 1'b1;
      wait_clks(1);
      stat_clr = 1'b0;
      check("R11", "status cleared", status, 0);
      check("R11", "irq cleared", irq, 0);
   endtask

   task automatic t_two();
      clear_all();
      send_sof();
      send_bits(8'h00, 8);
      send_bits(8'hFF, 8);
      end_frame();
      check("R9", "first byte", rx_data, 8'h00);
      pulse_rd();
      check("R9", "second valid", rx_valid, 1);
      check("R9", "second byte", rx_data, 8'hFF);
      pulse_rd();
      check("R9", "drained", rx_valid, 0);
      check("R10", "no overrun", status[3], 0);
   endtask

   task automatic t_overrun();
      clear_all();
      send_sof();
      send_bits(8'h11, 8);
      send_bits(8'h22, 8);
      send_bits(8'h33, 8);
      end_frame();
      check("R10", "overrun flag", status[3], 1);
      check("R10", "oldest kept", rx_data, 8'h11);
      pulse_rd();
      check("R10", "second kept", rx_data, 8'h22);
      pulse_rd();
      check("R10", "third dropped", rx_valid, 0);
   endtask

   // R3 and R8: after end of frame the receiver is idle, bits need a new start
   task automatic t_no_sof();
      clear_all();
      send_bits(8'hA5, 8);
      end_frame();
      check("R3", "no byte without sof", rx_valid, 0);
      check("R3", "no flags without sof", status, 0);
   endtask

   task automatic t_noise();
      clear_all();
      send_sof();
      for (int k = 0; k < 8; k++) begin
         hold(1'b0, 20);
         hold(1'b1, 20);
      end
      end_frame();
      check("R5", "no byte from glitches", rx_valid, 0);
      check("R5", "no framing err from glitches", status[2], 0);
   endtask

   task automatic t_partial();
      clear_all();
      send_sof();
      send_bits(8'hF0, 4);
      end_frame();
      check("R7", "framing err", status[2], 1);
      check("R7", "eod flag", status[0], 1);
      check("R7", "partial not delivered", rx_valid, 0);
   endtask

   task automatic t_restart();
      clear_all();
      send_sof();
      send_bits(8'hE0, 3);
      send_sof();
      send_bits(8'h5A, 8);
      end_frame();
      check("R6", "byte after restart", rx_data, 8'h5A);
      check("R6", "no framing err", status[2], 0);
   endtask

   initial begin
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(2);
      t_reset();
      hold(1'b0, 50);
      t_single();
      t_two();
      t_overrun();
      t_no_sof();
      t_noise();
      t_partial();
      t_restart();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errs++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule